// File: doc/BRIEF.md
# Time-Slot Routing Pointer Tracker

This block follows the position of a serial time-slot router as it walks through its routing table. It keeps a receive lane and a transmit lane. Each lane reports the index of the table entry that is active at the moment. An upstream sequencer pulses a per-lane done strobe when an entry has been handled. With that strobe it gives the "last" flag of the entry being finished. The tracker then moves to the next entry, or goes back to the first entry when the flag is set.

The table can be laid out in one of two ways. In the split layout (`layout_mode == 2'b00`) a lane covers up to 64 entries, using two 5-bit pointers. The low pointer counts through entries 1–32 while the high pointer is held at zero. The high pointer counts through entries 33–64 while the low pointer is held at zero. In every other layout only the low pointer is used, so a lane covers at most 32 entries. Each pointer carries a valid bit, so software can tell a real entry 0 from a pointer that is idle.

The result is one packed status word, built from registered state. Each 8-bit field holds a pointer in bits [4:0] and its valid bit in bit 5. Bits 7:6 of each field are reserved.

Top module: `slotptr_tracker`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after any cycle in which `enable` is low, every status bit is 0: both lanes have both pointers 0 and both valid bits 0. Done strobes are ignored during that time.
- R2: On the first edge with `enable` high after it was low, the lane shows the low pointer valid at value 0. A done strobe in that same cycle is ignored. In later cycles without a done strobe the status does not change.
- R3: A done strobe without the last flag, on a valid low pointer below 31, raises that pointer by exactly 1 on the next edge.
- R4: A done strobe with the last flag returns the lane to the low pointer, valid, at 0, from either half. A last flag on the entry at pointer 4 therefore gives the cycle 0,1,2,3,4,0.
- R5: In the split layout, a done strobe without the last flag when the low pointer is at 31 moves the lane to the high pointer. The high pointer becomes valid at 0, and the low pointer is cleared and made invalid. A last flag in that same cycle takes priority and gives R4 instead.
- R6: In the split layout, while the high half is active, done strobes without the last flag step the high pointer by 1, and the low pointer stays at 0. A done strobe without the last flag at high pointer 31 (entry 64) returns the lane to the low pointer at 0.
- R7: In any layout other than `2'b00`, a done strobe without the last flag at low pointer 31 wraps to 0. From the first edge after the layout leaves `2'b00`, the high pointer and its valid bit read 0. A lane that was in its high half restarts at low pointer 0.
- R8: At most one pointer of a lane is valid, and a pointer that is not valid reads 0.
- R9: The receive lane and the transmit lane step independently, following the same rules. A strobe or last flag on one lane never changes the other lane.
- R10: Status layout: transmit low at [4:0] with valid at [5], transmit high at [12:8] with valid at [13], receive low at [20:16] with valid at [21], receive high at [28:24] with valid at [29]. Bits 7:6, 15:14, 23:22 and 31:30 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low clears and idles both lanes |
| layout_mode | input | 2 | Table layout; 2'b00 selects the 64-entry split layout |
| rx_done | input | 1 | Receive lane: current entry finished |
| rx_last | input | 1 | Receive lane: finished entry is marked last |
| tx_done | input | 1 | Transmit lane: current entry finished |
| tx_last | input | 1 | Transmit lane: finished entry is marked last |
| status | output | 32 | Packed pointer/valid word (layout in R10) |

## Verification
Two lane functions can fall in the same cycle and must be resolved correctly. The first is the crossover from the low half to the high half. The second is the wrap caused by a last flag. They meet when a last-flagged entry sits at low pointer 31 in the split layout. The bench steps the receive lane to pointer 31 and finishes that entry with the last flag set. In the same cycle it steps the transmit lane to pointer 31 and finishes it without the flag. The receive lane is expected back at low pointer 0 and the transmit lane at high pointer 0. A done strobe that comes in the same cycle as `enable` falling is also driven, and it must leave every field cleared.

// File: rtl/slotptr_pkg.sv
package slotptr_pkg;

  // Which half of a lane's table window is currently active.
  typedef enum logic {
    HALF_A = 1'b0,
    HALF_B = 1'b1
  } half_e;

  // Layout code that selects the two-half (64-entry) window.
  localparam logic [1:0] LAYOUT_SPLIT = 2'b00;

  // Number of independent lanes and pointer fields per lane.
  localparam int LANES          = 2;
  localparam int HALVES         = 2;
  localparam int LANE_TX        = 0;
  localparam int LANE_RX        = 1;
  localparam int RSVD_BITS      = 2;

endpackage

// File: rtl/slotptr_lane.sv
module slotptr_lane
  import slotptr_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             split,
  input  logic             done,
  input  logic             last,
  output logic [PTR_W-1:0] a_ptr,
  output logic             a_vld,
  output logic [PTR_W-1:0] b_ptr,
  output logic             b_vld
);

  localparam logic [PTR_W-1:0] PTR_TOP = '1;

  logic             run_q;
  half_e            half_q;
  logic [PTR_W-1:0] ptr_q;

  // Arithmetic kept in functions so the rules read as stated.
  function automatic logic at_top(input logic [PTR_W-1:0] p);
    return p == PTR_TOP;
  endfunction

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // Named lane events.
  logic ev_step;   // an entry finished while running
  logic ev_cross;  // low half exhausted, move to high half
  logic ev_wrap;   // last flag or end of window: back to low 0
  logic ev_fold;   // layout left split mode while in the high half

  assign ev_step  = run_q && enable && done;
  assign ev_cross = ev_step && !last && at_top(ptr_q) && split && (half_q == HALF_A);
  assign ev_wrap  = ev_step && (last || (at_top(ptr_q) && !(split && (half_q == HALF_A))));
  assign ev_fold  = run_q && enable && !split && (half_q == HALF_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      half_q <= HALF_A;
      ptr_q  <= '0;
    end else if (!enable) begin
      run_q  <= 1'b0;
      half_q <= HALF_A;
      ptr_q  <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      half_q <= HALF_A;
      ptr_q  <= '0;
    end else if (ev_fold || ev_wrap) begin
      half_q <= HALF_A;
      ptr_q  <= '0;
    end else if (ev_cross) begin
      half_q <= HALF_B;
      ptr_q  <= '0;
    end else if (ev_step) begin
      ptr_q  <= bump(ptr_q);
    end
  end

  assign a_vld = run_q && (half_q == HALF_A);
  assign b_vld = run_q && (half_q == HALF_B);
  assign a_ptr = a_vld ? ptr_q : '0;
  assign b_ptr = b_vld ? ptr_q : '0;

  // ---------------- assertions ----------------
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!a_vld && !b_vld && a_ptr == '0 && b_ptr == '0));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (a_vld && !b_vld && a_ptr == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !done && (a_vld || b_vld) && (split || !b_vld))
      |=> $stable({a_vld, a_ptr, b_vld, b_ptr}));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && done && !last && a_vld && !at_top(a_ptr))
      |=> (a_vld && a_ptr == bump($past(a_ptr))));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && done && last && (a_vld || b_vld))
      |=> (a_vld && !b_vld && a_ptr == '0));

  p_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && split && done && !last && a_vld && at_top(a_ptr))
      |=> (b_vld && !a_vld && b_ptr == '0 && a_ptr == '0));

  p_bstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && split && done && !last && b_vld && !at_top(b_ptr))
      |=> (b_vld && a_ptr == '0 && b_ptr == bump($past(b_ptr))));

  p_bend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && split && done && !last && b_vld && at_top(b_ptr))
      |=> (a_vld && !b_vld && a_ptr == '0));

  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !split |=> (!b_vld && b_ptr == '0));

  p_singlewrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !split && done && !last && a_vld && at_top(a_ptr))
      |=> (a_vld && a_ptr == '0));

endmodule

// File: rtl/slotptr_pack.sv
module slotptr_pack
  import slotptr_pkg::*;
#(
  parameter int PTR_W   = 5,
  parameter int FIELDS  = 4,
  parameter int FIELD_W = PTR_W + 1 + RSVD_BITS
) (
  input  logic [FIELDS-1:0][PTR_W-1:0] ptr_f,
  input  logic [FIELDS-1:0]            vld_f,
  output logic [FIELDS*FIELD_W-1:0]    word
);

  localparam int PAD_W = FIELD_W - PTR_W - 1;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    assign word[i*FIELD_W +: FIELD_W] = {{PAD_W{1'b0}}, vld_f[i], ptr_f[i]};
  end

endmodule

// File: rtl/slotptr_tracker.sv
module slotptr_tracker
  import slotptr_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         enable,
  input  logic [1:0]                                   layout_mode,
  input  logic                                         rx_done,
  input  logic                                         rx_last,
  input  logic                                         tx_done,
  input  logic                                         tx_last,
  output logic [LANES*HALVES*(PTR_W+1+RSVD_BITS)-1:0]  status
);

  localparam int FIELD_W = PTR_W + 1 + RSVD_BITS;
  localparam int FIELDS  = LANES * HALVES;

  logic                            split;
  logic [LANES-1:0]                done_v;
  logic [LANES-1:0]                last_v;
  logic [FIELDS-1:0][PTR_W-1:0]    ptr_f;
  logic [FIELDS-1:0]               vld_f;

  assign split           = (layout_mode == LAYOUT_SPLIT);
  assign done_v[LANE_TX] = tx_done;
  assign done_v[LANE_RX] = rx_done;
  assign last_v[LANE_TX] = tx_last;
  assign last_v[LANE_RX] = rx_last;

  for (genvar d = 0; d < LANES; d++) begin : g_lane
    slotptr_lane #(.PTR_W(PTR_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .split  (split),
      .done   (done_v[d]),
      .last   (last_v[d]),
      .a_ptr  (ptr_f[HALVES*d]),
      .a_vld  (vld_f[HALVES*d]),
      .b_ptr  (ptr_f[HALVES*d+1]),
      .b_vld  (vld_f[HALVES*d+1])
    );
  end

  slotptr_pack #(.PTR_W(PTR_W), .FIELDS(FIELDS), .FIELD_W(FIELD_W)) u_pack (
    .ptr_f (ptr_f),
    .vld_f (vld_f),
    .word  (status)
  );

  // R9: a lane whose strobe is idle keeps its fields while the other steps.
  p_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tx_done && rx_done && (vld_f[0] || vld_f[1]) && (split || !vld_f[1]))
      |=> $stable(status[HALVES*FIELD_W-1:0]));

endmodule

// File: tb/slotptr_tracker_bench.sv
module slotptr_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  layout_mode = 2'b01;
  logic        rx_done = 1'b0, rx_last = 1'b0, tx_done = 1'b0, tx_last = 1'b0;
  logic [31:0] status;

  always #2.5 clk = ~clk;  // 200 MHz

  slotptr_tracker u_slotptr_tracker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .layout_mode(layout_mode),
    .rx_done(rx_done), .rx_last(rx_last), .tx_done(tx_done), .tx_last(tx_last),
    .status(status)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  // Reference state per lane: running flag and combined entry index 0..63.
  bit m_run[2];
  int m_idx[2];

  // R10 layout: per lane 16 bits, low field then high field.
  function automatic logic [15:0] lane_word(bit run, int idx);
    logic [7:0] lo, hi;
    bit a, b;
    a  = run && idx < 32;
    b  = run && idx >= 32;
    lo = {2'b00, a, a ? 5'(idx) : 5'd0};
    hi = {2'b00, b, b ? 5'(idx - 32) : 5'd0};
    return {hi, lo};
  endfunction

  task automatic drive(input bit en, input logic [1:0] mode,
                       input bit rxd, input bit rxl, input bit txd, input bit txl,
                       input string tag);
    bit dn, ls;
    int lim;
    @(negedge clk);
    enable = en; layout_mode = mode;
    rx_done = rxd; rx_last = rxl; tx_done = txd; tx_last = txl;
    for (int d = 0; d < 2; d++) begin
      dn  = (d == 1) ? rxd : txd;
      ls  = (d == 1) ? rxl : txl;
      lim = (mode == 2'b00) ? 64 : 32;
      if (!en) begin m_run[d] = 0; m_idx[d] = 0; end
      else if (!m_run[d]) begin m_run[d] = 1; m_idx[d] = 0; end
      else if (mode != 2'b00 && m_idx[d] >= 32) m_idx[d] = 0;
      else if (dn) begin
        if (ls || m_idx[d] + 1 == lim) m_idx[d] = 0;
        else m_idx[d] = m_idx[d] + 1;
      end
    end
    q_exp.push_back({lane_word(m_run[1], m_idx[1]), lane_word(m_run[0], m_idx[0])});
    q_tag.push_back(tag);
  endtask

  // Monitor: compare one expected word per clock, 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (status !== e) begin
          errors++;
          $display("FAIL %s: status actual %h expected %h", t, status, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #50000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (status !== 32'h0) begin
      errors++;
      $display("FAIL R1 in reset: status actual %h expected %h", status, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: strobes while disabled are ignored.
    for (int k = 0; k < 3; k++) drive(0, 2'b01, 1, 0, 1, 1, "R1 disabled strobes");
    // R2: enable start, strobe in that cycle ignored.
    drive(1, 2'b01, 1, 0, 1, 0, "R2 enable start");
    drive(1, 2'b01, 0, 0, 0, 0, "R2 hold without strobe");
    // R4/R9/R10: rx last on pointer 4, tx idle.
    for (int k = 0; k < 12; k++)
      drive(1, 2'b01, 1, (k % 5) == 4, 0, 0, "R4 R9 R10 rx five-entry cycle");
    // R3/R7: tx single layout walks 40 entries, wrapping at 32.
    for (int k = 0; k < 40; k++)
      drive(1, 2'b01, 0, 0, 1, 0, "R3 R7 tx single-layout wrap");
    // R5/R6/R8: split layout, tx walks past 64, rx every other cycle.
    for (int k = 0; k < 70; k++)
      drive(1, 2'b00, k % 2, 0, 1, 0, "R5 R6 R8 split walk");
    // R1: disable clears.
    drive(0, 2'b00, 0, 0, 0, 0, "R1 disable clears");
    drive(1, 2'b00, 0, 0, 0, 0, "R2 re-enable");
    for (int k = 0; k < 31; k++)
      drive(1, 2'b00, 1, 0, 1, 0, "R3 climb to 31");
    // Collision: rx last at 31 (wrap), tx no last at 31 (crossover).
    drive(1, 2'b00, 1, 1, 1, 0, "R4 R5 R9 last vs crossover");
    for (int k = 0; k < 3; k++)
      drive(1, 2'b00, 0, 0, 1, 0, "R6 high-half step");
    drive(1, 2'b00, 0, 0, 1, 1, "R4 last in high half");
    for (int k = 0; k < 34; k++)
      drive(1, 2'b00, 0, 0, 1, 0, "R5 R6 back into high half");
    // R7: leaving split layout while in the high half.
    drive(1, 2'b10, 0, 0, 0, 0, "R7 fold to low half");
    drive(1, 2'b10, 1, 0, 1, 0, "R7 single layout step");
    // R1: strobe coincides with disable.
    drive(0, 2'b10, 1, 0, 1, 0, "R1 strobe with disable");
    drive(0, 2'b00, 0, 0, 0, 0, "R1 idle");

    while (q_exp.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule